// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial bus (I2C style) placed in front of a byte-wide memory array. It watches the clock and data lines with the system clock and decodes start and stop conditions. It receives a device byte, address bytes and write data, and shifts read data back out. The data line is driven only through an open-drain enable, so the slave can only pull the line low.

An internal address counter always points one past the byte most recently read or written. A master can use it in four ways:
- Read from the counter's current position.
- Load it with a dummy write of two address bytes and then read after a repeated start.
- Load it and end with a stop, so that a later read starts from the new position.
- Write one byte or a run of bytes into a single page.

Reads step through the whole array and wrap to zero after the last address. Writes wrap to the first byte of the same page and never spill into the next page. The array size and page size are parameters; the default array holds 2 KB.

Top module: `serial_mem_slave`

## Requirements
- R1: While reset is asserted, and after it is released, the slave does not pull the data line low until it has received a matching device byte.
- R2: The device byte is matched MSB first. Bits 7..4 must be 1010, bit 3 must be 0, bits 2..1 must equal the `devSel` input, and bit 0 is the direction (1 = read). On a match the slave pulls the data line low during the 9th clock. On a mismatch it gives no acknowledge and acknowledges nothing until the next start.
- R3: A write-direction device byte is followed by a high address byte and then a low address byte, each acknowledged. The address is the low `ADDR_W` bits of {high, low}, and it is loaded into the counter. A repeated start and a read-direction device byte then return the byte stored at that address.
- R4: If a stop follows the low address byte, the counter keeps the loaded address and no data is sent. The next read without address bytes starts at that address.
- R5: In a read, each master acknowledge (data line low on the 9th clock) makes the slave send the byte at the next address. After the last array address, reading continues from address 0.
- R6: A read without address bytes returns the byte at the counter, which is one past the last byte read or written.
- R7: Write data bytes are stored at the counter and each one is acknowledged. The counter then advances only its low `PAGE_W` bits, so after the last byte of a page the next byte goes to the first byte of the same page, and the upper address bits stay unchanged.
- R8: When the master gives no acknowledge (data line high on the 9th clock) after a read byte, the slave releases the data line and ignores all further clocks until the next start.
- R9: A start seen in any state, including the middle of a byte, abandons the current transfer and begins reception of a new device byte.
- R10: Read data is sent MSB first. The slave changes its data output only while the clock is low, and it releases the line during the master's acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus lines |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus (wired-AND value) |
| devSel | input | 2 | Device select value that the device byte must match |
| sdaOe | output | 1 | When 1, the slave pulls the data line low |

## Verification
The checks assume that each low and high phase of the serial clock lasts at least three system clocks. They also assume that the master moves the data line only while the clock is low, except when it signals a start or a stop. Under these conditions every new low the slave drives begins while the clock input is still low. The bench builds every bus phase from a quarter period of three system clocks and uses a wired-AND model of the data line. It uses a 512-byte array with 16-byte pages, so a sweep across the whole array and its wrap fits in the run.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

  // Strobes from the bus control to the memory datapath, one cycle each.
  typedef struct packed {
    logic       shift;     // shift bitVal into the receive register
    logic       bitVal;    // sampled data line value
    logic       latchHi;   // capture received byte as upper address bits
    logic       loadAddr;  // load counter from upper bits + received byte
    logic       wrMem;     // store received byte, page-local increment
    logic       fetch;     // read array at counter, drive MSB, increment
    logic       driveAck;  // pull data line low for an acknowledge
    logic       relBus;    // let the data line go
    logic       driveBit;  // drive bit bitSel of the transmit byte
    logic [2:0] bitSel;
  } memStrb_t;

endpackage

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import serial_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] devSel,
  input  logic [7:0] rxByte,
  output memStrb_t   strb
);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEVACK, S_AHI, S_AHIACK, S_ALO, S_ALOACK,
    S_WDAT, S_WACK, S_RDAT, S_RACK
  } busState_t;

  busState_t state, stateN;
  logic [3:0] bitCnt, cntN;
  logic       isRead, readN;
  logic       sclQ, sclP, sdaQ, sdaP;
  logic       sclRise, sclFall, startEv, stopEv, devMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1; sclP <= 1'b1; sdaQ <= 1'b1; sdaP <= 1'b1;
    end else begin
      sclQ <= sclIn; sclP <= sclQ; sdaQ <= sdaIn; sdaP <= sdaQ;
    end
  end

  assign sclRise  = sclQ & ~sclP;
  assign sclFall  = ~sclQ & sclP;
  assign startEv  = sclQ & sclP & sdaP & ~sdaQ;
  assign stopEv   = sclQ & sclP & ~sdaP & sdaQ;
  assign devMatch = (rxByte[7:1] == {4'b1010, 1'b0, devSel});

  always_comb begin
    strb        = '0;
    strb.bitVal = sdaQ;
    stateN      = state;
    cntN        = bitCnt;
    readN       = isRead;
    if (startEv) begin
      stateN = S_DEV; cntN = '0; strb.relBus = 1'b1;
    end else if (stopEv) begin
      stateN = S_IDLE; cntN = '0; strb.relBus = 1'b1;
    end else if (sclRise) begin
      case (state)
        S_DEV, S_AHI, S_ALO, S_WDAT: begin
          strb.shift = 1'b1;
          cntN = bitCnt + 4'd1;
        end
        S_RDAT: cntN = bitCnt + 4'd1;
        S_RACK: if (sdaQ) stateN = S_IDLE;
        default: ;
      endcase
    end else if (sclFall) begin
      case (state)
        S_DEV: if (bitCnt == 4'd8) begin
          if (devMatch) begin
            strb.driveAck = 1'b1; readN = rxByte[0]; stateN = S_DEVACK;
          end else begin
            stateN = S_IDLE;
          end
        end
        S_AHI: if (bitCnt == 4'd8) begin
          strb.latchHi = 1'b1; strb.driveAck = 1'b1; stateN = S_AHIACK;
        end
        S_ALO: if (bitCnt == 4'd8) begin
          strb.loadAddr = 1'b1; strb.driveAck = 1'b1; stateN = S_ALOACK;
        end
        S_WDAT: if (bitCnt == 4'd8) begin
          strb.wrMem = 1'b1; strb.driveAck = 1'b1; stateN = S_WACK;
        end
        S_DEVACK: begin
          cntN = '0;
          if (isRead) begin
            strb.fetch = 1'b1; stateN = S_RDAT;
          end else begin
            strb.relBus = 1'b1; stateN = S_AHI;
          end
        end
        S_AHIACK: begin strb.relBus = 1'b1; cntN = '0; stateN = S_ALO;  end
        S_ALOACK: begin strb.relBus = 1'b1; cntN = '0; stateN = S_WDAT; end
        S_WACK:   begin strb.relBus = 1'b1; cntN = '0; stateN = S_WDAT; end
        S_RDAT: begin
          if (bitCnt == 4'd8) begin
            strb.relBus = 1'b1; stateN = S_RACK;
          end else begin
            strb.driveBit = 1'b1;
            strb.bitSel   = 3'(4'd7 - bitCnt);
          end
        end
        S_RACK: begin strb.fetch = 1'b1; cntN = '0; stateN = S_RDAT; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
    end else begin
      state  <= stateN;
      bitCnt <= cntN;
      isRead <= readN;
    end
  end

endmodule

// File: rtl/smem_dpath.sv
module smem_dpath
  import serial_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrb_t          strb,
  output logic [7:0]        rxByte,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] addrCnt
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  logic [7:0]        mem [DEPTH];
  logic [7:0]        shiftReg, txByte, rdData;
  logic [HI_W-1:0]   hiBits;
  logic [ADDR_W-1:0] pageNext;

  assign rdData   = mem[addrCnt];
  assign rxByte   = shiftReg;
  assign pageNext = {addrCnt[ADDR_W-1:PAGE_W], addrCnt[PAGE_W-1:0] + 1'b1};

  always_ff @(posedge clk) begin
    if (strb.wrMem) mem[addrCnt] <= shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      txByte   <= '0;
      hiBits   <= '0;
      addrCnt  <= '0;
      sdaOe    <= 1'b0;
    end else begin
      if (strb.shift)    shiftReg <= {shiftReg[6:0], strb.bitVal};
      if (strb.latchHi)  hiBits   <= shiftReg[HI_W-1:0];
      if (strb.loadAddr) addrCnt  <= {hiBits, shiftReg};
      if (strb.wrMem)    addrCnt  <= pageNext;
      if (strb.fetch) begin
        txByte  <= rdData;
        addrCnt <= addrCnt + 1'b1;
      end
      if (strb.relBus)        sdaOe <= 1'b0;
      else if (strb.driveAck) sdaOe <= 1'b1;
      else if (strb.fetch)    sdaOe <= ~rdData[7];
      else if (strb.driveBit) sdaOe <= ~txByte[strb.bitSel];
    end
  end

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import serial_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] devSel,
  output logic       sdaOe
);

  memStrb_t          strb;
  logic [7:0]        rxByte;
  logic [ADDR_W-1:0] addrCnt;

  smem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devSel(devSel), .rxByte(rxByte), .strb(strb)
  );

  smem_dpath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxByte(rxByte), .sdaOe(sdaOe), .addrCnt(addrCnt)
  );

endmodule

// File: rtl/smem_checker.sv
module smem_checker
  import serial_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input memStrb_t          strb,
  input logic [ADDR_W-1:0] addrCnt
);

  p_quiet_in_reset_r1: assert property (@(posedge clk) !rstN |-> !sdaOe);

  // R10: a new low is only ever started while the clock line is low
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  p_read_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetch |=> addrCnt == ADDR_W'($past(addrCnt) + 1'b1));

  p_page_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMem |=> (addrCnt[PAGE_W-1:0] == PAGE_W'($past(addrCnt[PAGE_W-1:0]) + 1'b1))
               && (addrCnt[ADDR_W-1:PAGE_W] == $past(addrCnt[ADDR_W-1:PAGE_W])));

  p_single_access_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fetch, strb.wrMem, strb.loadAddr}));

endmodule

bind serial_mem_slave smem_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .strb(strb), .addrCnt(addrCnt)
);

// File: tb/serial_mem_slave_tb.sv
module serial_mem_slave_tb;

  localparam int AW    = 9;
  localparam int PW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;
  localparam int Q     = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       mLow = 1'b0;
  logic [1:0] devSel = 2'b10;
  logic       sdaOe;
  logic       sdaBus;
  int         total = 0;
  int         bad = 0;
  logic [7:0] model [DEPTH];

  assign sdaBus = ~(mLow | sdaOe);

  always #2 clk = ~clk;

  serial_mem_slave #(.ADDR_W(AW), .PAGE_W(PW)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .devSel(devSel), .sdaOe(sdaOe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] devByte(input logic rw);
    return {4'b1010, 1'b0, devSel, rw};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic clk1(input bit b, output bit s);
    mLow = ~b; qwait; scl = 1'b1; qwait; s = sdaBus; qwait; scl = 1'b0; qwait;
  endtask

  task automatic startC;
    mLow = 1'b0; qwait; scl = 1'b1; qwait; mLow = 1'b1; qwait; scl = 1'b0; qwait;
  endtask

  task automatic stopC;
    mLow = 1'b1; qwait; scl = 1'b1; qwait; mLow = 1'b0; qwait;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk1(b[i], s);
    clk1(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(output logic [7:0] b, input bit mAck);
    bit s;
    for (int i = 7; i >= 0; i--) begin clk1(1'b1, s); b[i] = s; end
    clk1(~mAck, s);
  endtask

  task automatic setAddr(input int a, output bit allAck);
    bit k0, k1, k2;
    startC;
    sendByte(devByte(1'b0), k0);
    sendByte(8'(a >> 8), k1);
    sendByte(8'(a), k2);
    allAck = k0 & k1 & k2;
  endtask

  task automatic curRead(output logic [7:0] b, output bit ack);
    startC;
    sendByte(devByte(1'b1), ack);
    recvByte(b, 1'b0);
    stopC;
  endtask

  task automatic randRead1(input int a, output logic [7:0] b);
    bit k, k2;
    setAddr(a, k);
    startC;
    sendByte(devByte(1'b1), k2);
    recvByte(b, 1'b0);
    stopC;
    chk(k & k2, "R3 acks", int'(k & k2), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    bit ack, s, allOk;
    int a;

    for (int i = 0; i < DEPTH; i++) model[i] = pat(i);

    // R1: reset behaviour
    repeat (5) @(negedge clk);
    chk(sdaOe == 1'b0, "R1 in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    chk(sdaOe == 1'b0, "R1 after reset", int'(sdaOe), 0);

    // R2: select mismatch, fixed-bit mismatch, then ignored follow-up byte
    startC;
    sendByte({4'b1010, 1'b0, ~devSel, 1'b0}, ack);
    chk(!ack, "R2 wrong select", int'(ack), 0);
    sendByte(8'h00, ack);
    chk(!ack, "R2 ignored after mismatch", int'(ack), 0);
    stopC;
    startC;
    sendByte({4'b1010, 1'b1, devSel, 1'b0}, ack);
    chk(!ack, "R2 bit3 set", int'(ack), 0);
    stopC;
    startC;
    sendByte({4'b1011, 1'b0, devSel, 1'b0}, ack);
    chk(!ack, "R2 wrong prefix", int'(ack), 0);
    stopC;

    // R7: fill the array with page writes
    for (int p = 0; p < DEPTH / PAGE; p++) begin
      setAddr(p * PAGE, allOk);
      for (int i = 0; i < PAGE; i++) begin
        sendByte(pat(p * PAGE + i), ack);
        allOk &= ack;
      end
      stopC;
      chk(allOk, "R7 page write acks", int'(allOk), 1);
    end

    // R3 random reads and R6 current-address follow-ups (R5 wrap at 511)
    foreach (model[i]) begin end
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: a = 0;   1: a = 5;   2: a = 255;
        3: a = 256; 4: a = 300; default: a = DEPTH - 1;
      endcase
      randRead1(a, b);
      chk(b == model[a], "R3 random read", int'(b), int'(model[a]));
      curRead(b, ack);
      chk(ack && b == model[(a + 1) % DEPTH], "R6 current read",
          int'(b), int'(model[(a + 1) % DEPTH]));
    end

    // R5: sequential read across the end of the array
    setAddr(DEPTH - 16, allOk);
    startC;
    sendByte(devByte(1'b1), ack);
    chk(allOk & ack, "R5 setup acks", int'(allOk & ack), 1);
    for (int i = 0; i < DEPTH + 8; i++) begin
      recvByte(b, i != DEPTH + 7);
      a = (DEPTH - 16 + i) % DEPTH;
      chk(b == model[a], "R5 sequential", int'(b), int'(model[a]));
    end
    stopC;
    curRead(b, ack);
    a = (DEPTH - 16 + DEPTH + 8) % DEPTH;
    chk(b == model[a], "R6 after sequential", int'(b), int'(model[a]));

    // R4: dummy write ended by stop loads the counter
    setAddr(77, allOk);
    stopC;
    chk(sdaOe == 1'b0, "R4 no data after stop", int'(sdaOe), 0);
    curRead(b, ack);
    chk(allOk && b == model[77], "R4 set address", int'(b), int'(model[77]));

    // R7: page wrap on write, page 3 offset 14, values probe MSB order (R10)
    setAddr(3 * PAGE + 14, allOk);
    sendByte(8'h80, ack); allOk &= ack; model[3 * PAGE + 14] = 8'h80;
    sendByte(8'h01, ack); allOk &= ack; model[3 * PAGE + 15] = 8'h01;
    sendByte(8'hC3, ack); allOk &= ack; model[3 * PAGE + 0]  = 8'hC3;
    sendByte(8'h5A, ack); allOk &= ack; model[3 * PAGE + 1]  = 8'h5A;
    stopC;
    chk(allOk, "R7 wrap write acks", int'(allOk), 1);
    curRead(b, ack);
    chk(b == model[3 * PAGE + 2], "R7 counter after page wrap",
        int'(b), int'(model[3 * PAGE + 2]));
    randRead1(3 * PAGE + 14, b);
    chk(b == 8'h80, "R10 msb first 80", int'(b), 8'h80);
    curRead(b, ack);
    chk(b == 8'h01, "R10 lsb set 01", int'(b), 8'h01);
    for (int i = 0; i < 3; i++) begin
      randRead1(3 * PAGE + i, b);
      chk(b == model[3 * PAGE + i], "R7 page start data",
          int'(b), int'(model[3 * PAGE + i]));
    end
    randRead1(4 * PAGE, b);
    chk(b == model[4 * PAGE], "R7 next page untouched",
        int'(b), int'(model[4 * PAGE]));

    // R8: after a NACK the slave stays off the bus
    randRead1(10, b);
    chk(b == model[10], "R8 read before nack", int'(b), int'(model[10]));
    setAddr(20, allOk);
    startC;
    sendByte(devByte(1'b1), ack);
    recvByte(b, 1'b0);
    allOk = 1'b1;
    for (int i = 0; i < 9; i++) begin
      clk1(1'b1, s);
      allOk &= s;
    end
    chk(allOk, "R8 bus released after nack", int'(allOk), 1);
    stopC;

    // R9: start in mid byte restarts reception
    startC;
    for (int i = 0; i < 4; i++) clk1(1'b1, s);
    randRead1(123, b);
    chk(b == model[123], "R9 restart mid byte", int'(b), int'(model[123]));
    startC;
    sendByte(devByte(1'b0), ack);
    sendByte(8'h00, ack);
    for (int i = 0; i < 3; i++) clk1(1'b0, s);
    startC;
    sendByte(devByte(1'b1), ack);
    recvByte(b, 1'b0);
    stopC;
    chk(ack && b == model[124], "R9 restart in address byte",
        int'(b), int'(model[124]));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule